// File: doc/BRIEF.md
# Banked Register Window for a Serial-Bus Slave

This block is the register file behind a byte-addressed serial-bus slave whose internal register space is 9 bits wide but whose bus address is only 8 bits wide. The missing address bit comes from a bank-select register. The lowest 48 offsets of the window form a common region that stays reachable whatever bank is selected. Offsets above that region are steered by the bank bit. With bank 0 they reach a block of general-purpose storage. With bank 1 they reach the packet registers.

A simple register bus drives the block: an address, write data, a write strobe, a read strobe and registered read data. The decoder sorts every access into a register class. It answers unmapped reads with zero. It drops writes that have no writable target and flags each one with an error pulse. The registers also drive hardware directly: a set of held sub-block reset outputs, a programmable secondary slave address with its enable, packet enable and repeat controls, and the packet payload together with its checksum. Two status pins pass through a synchronizer and can be read back.

Top module: `bwin_regwin`

## Requirements
- R1: Window offsets 0x00..0x2F reach the same registers whether the bank bit is 0 or 1.
- R2: Bit 0 of offset 0x0F is the bank bit; the other bits of that register read 0. With the bank bit at 0, offsets 0x30..0xFF reach general read/write byte storage. With the bank bit at 1, they reach internal addresses 0x130..0x1FF.
- R3: Offset 0x0E is read-only status. Bit 6 shows the hot-plug pin and bit 4 shows the video-stable pin, each delayed by the synchronizer stages. All other bits read 0. A write to it changes nothing and raises the error pulse.
- R4: Offset 0x04 holds reset bits: bit 5 reference, bit 4 audio path, bit 3 video, bit 2 audio, bit 0 content protection. Each bit drives its own active-high reset output for as long as it is set. Bits 7, 6 and 1 read 0.
- R5: Offset 0x1D holds the secondary slave address pre-shifted left by one. Bit 0 reads 0 and the address output equals bits 7:1. Bit 0 of offset 0x1E is the enable output and its other bits read 0.
- R6: Internal addresses 0x158..0x165 (bank 1, offsets 0x58..0x65) hold 14 read/write bytes. Address 0x15D is the checksum output. The 13 data bytes, in address order with the checksum skipped, appear on the payload output with the first byte in bits 7:0.
- R7: Internal address 0x1CD (bank 1, offset 0xCD) holds the packet controls: bit 0 is enable and bit 1 is repeat. Its other bits read 0.
- R8: A read of an unmapped address returns 0x00. This covers common offsets other than 0x04, 0x0E, 0x0F, 0x1D and 0x1E, and bank-1 addresses outside the packet bytes and the control register.
- R9: A write to an unmapped or read-only address changes no register. It raises the error output for exactly the cycle after the write, once for each such write.
- R10: Asynchronous reset clears every register, including the bank bit, the read data and the error output.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Window offset |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | Pulse for a dropped write |
| hpd_i | input | 1 | Hot-plug detect pin |
| vid_stable_i | input | 1 | Video-stable pin |
| rst_ref_o | output | 1 | Reference reset |
| rst_apath_o | output | 1 | Audio path reset |
| rst_vid_o | output | 1 | Video reset |
| rst_aud_o | output | 1 | Audio reset |
| rst_prot_o | output | 1 | Content-protection reset |
| alias_addr_o | output | 7 | Secondary slave address |
| alias_en_o | output | 1 | Secondary slave enable |
| pkt_en_o | output | 1 | Packet enable |
| pkt_rpt_o | output | 1 | Packet repeat |
| pkt_data_o | output | 104 | Packet data bytes, first byte lowest |
| pkt_csum_o | output | 8 | Packet checksum |

## Verification
The assertions rely on the strobes being low while reset is asserted. They also rely on the address and write data being stable for the whole cycle in which a strobe is high. The bench keeps to this by changing every input only on the falling clock edge and holding the strobes low throughout reset. The status pins are treated as slow signals: the bench changes them only while the bus is idle and waits longer than the synchronizer depth before it reads them. Random traffic covers both banks and every register class, and it mixes simultaneous reads and writes with back-to-back dropped writes.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
    localparam int DW          = 8;
    localparam int PKT_BYTES   = 14;
    localparam int PKT_CSUM_IX = 5;

    localparam logic [7:0] A_SWRST    = 8'h04;
    localparam logic [7:0] A_STATUS   = 8'h0E;
    localparam logic [7:0] A_BANK     = 8'h0F;
    localparam logic [7:0] A_ALIAS    = 8'h1D;
    localparam logic [7:0] A_ALIAS_EN = 8'h1E;
    localparam logic [7:0] COMMON_TOP = 8'h2F;

    localparam logic [8:0] I_PKT_FIRST = 9'h158;
    localparam logic [8:0] I_PKT_LAST  = 9'h165;
    localparam logic [8:0] I_PKT_CTL   = 9'h1CD;

    localparam logic [7:0] M_SWRST = 8'h3D;

    typedef enum logic [3:0] {
        CL_NONE, CL_SWRST, CL_STATUS, CL_BANK, CL_ALIAS,
        CL_ALIAS_EN, CL_GP, CL_PKT, CL_PKT_CTL
    } reg_class_e;

    typedef struct packed {
        logic [7:0]             swrst;
        logic                   bank;
        logic [6:0]             alias_addr;
        logic                   alias_en;
        logic [1:0]             pkt_ctl;
        logic [PKT_BYTES*8-1:0] pkt;
        logic [7:0]             rdata;
        logic                   err;
    } win_state_t;
endpackage

// File: rtl/bwin_decode.sv
module bwin_decode
    import bwin_pkg::*;
#(
    parameter int GP_DEPTH = 208
) (
    input  logic [7:0] addr_i,
    input  logic       bank_i,
    output reg_class_e cls_o,
    output logic [7:0] off_o
);
    localparam int GP_FIRST = int'(COMMON_TOP) + 1;
    localparam int GP_LIMIT = GP_FIRST + GP_DEPTH;

    logic [8:0] iaddr;
    logic [8:0] pkt_diff;

    always_comb begin
        iaddr    = (addr_i <= COMMON_TOP) ? {1'b0, addr_i} : {bank_i, addr_i};
        pkt_diff = iaddr - I_PKT_FIRST;
        cls_o    = CL_NONE;
        off_o    = '0;
        if (addr_i <= COMMON_TOP) begin
            case (addr_i)
                A_SWRST:    cls_o = CL_SWRST;
                A_STATUS:   cls_o = CL_STATUS;
                A_BANK:     cls_o = CL_BANK;
                A_ALIAS:    cls_o = CL_ALIAS;
                A_ALIAS_EN: cls_o = CL_ALIAS_EN;
                default:    cls_o = CL_NONE;
            endcase
        end else if (!iaddr[8]) begin
            if (int'(addr_i) >= GP_FIRST && int'(addr_i) < GP_LIMIT) begin
                cls_o = CL_GP;
                off_o = addr_i - 8'(GP_FIRST);
            end
        end else if (iaddr >= I_PKT_FIRST && iaddr <= I_PKT_LAST) begin
            cls_o = CL_PKT;
            off_o = pkt_diff[7:0];
        end else if (iaddr == I_PKT_CTL) begin
            cls_o = CL_PKT_CTL;
        end
    end
endmodule

// File: rtl/bwin_sync.sv
module bwin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    if (STAGES == 0) begin : g_bypass
        assign q_o = d_i;
    end else begin : g_chain
        logic [WIDTH-1:0] stg_d [STAGES];
        logic [WIDTH-1:0] stg_q [STAGES];

        always_comb begin
            stg_d[0] = d_i;
            for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            end else begin
                for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
            end
        end

        assign q_o = stg_q[STAGES-1];
    end
endmodule

// File: rtl/bwin_gp_store.sv
module bwin_gp_store #(
    parameter int DEPTH = 208,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic       in_range;

    assign in_range = int'(idx_i) < DEPTH;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we_i && in_range) mem_d[idx_i] = wdata_i;
        rdata_o = in_range ? mem_q[idx_i] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/bwin_regwin.sv
module bwin_regwin
    import bwin_pkg::*;
#(
    parameter int GP_DEPTH    = 208,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   addr_i,
    input  logic [7:0]   wdata_i,
    input  logic         wr_en_i,
    input  logic         rd_en_i,
    output logic [7:0]   rdata_o,
    output logic         err_o,
    input  logic         hpd_i,
    input  logic         vid_stable_i,
    output logic         rst_ref_o,
    output logic         rst_apath_o,
    output logic         rst_vid_o,
    output logic         rst_aud_o,
    output logic         rst_prot_o,
    output logic [6:0]   alias_addr_o,
    output logic         alias_en_o,
    output logic         pkt_en_o,
    output logic         pkt_rpt_o,
    output logic [103:0] pkt_data_o,
    output logic [7:0]   pkt_csum_o
);
    localparam int GP_AW = $clog2(GP_DEPTH);

    win_state_t st_d, st_q;
    reg_class_e cls;
    logic [7:0] off;
    logic [1:0] stat_s;
    logic [7:0] gp_rdata;
    logic       gp_we;
    logic [7:0] rd_val;
    logic [6:0] pkt_bit;

    bwin_decode #(.GP_DEPTH(GP_DEPTH)) u_decode (
        .addr_i (addr_i),
        .bank_i (st_q.bank),
        .cls_o  (cls),
        .off_o  (off)
    );

    bwin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({hpd_i, vid_stable_i}),
        .q_o   (stat_s)
    );

    bwin_gp_store #(.DEPTH(GP_DEPTH)) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (gp_we),
        .idx_i   (off[GP_AW-1:0]),
        .wdata_i (wdata_i),
        .rdata_o (gp_rdata)
    );

    assign pkt_bit = {off[3:0], 3'b000};

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        gp_we    = 1'b0;
        case (cls)
            CL_SWRST:    rd_val = st_q.swrst;
            CL_STATUS:   rd_val = {1'b0, stat_s[1], 1'b0, stat_s[0], 4'b0000};
            CL_BANK:     rd_val = {7'b0, st_q.bank};
            CL_ALIAS:    rd_val = {st_q.alias_addr, 1'b0};
            CL_ALIAS_EN: rd_val = {7'b0, st_q.alias_en};
            CL_GP:       rd_val = gp_rdata;
            CL_PKT:      rd_val = st_q.pkt[pkt_bit +: 8];
            CL_PKT_CTL:  rd_val = {6'b0, st_q.pkt_ctl};
            default:     rd_val = 8'h00;
        endcase
        if (rd_en_i) st_d.rdata = rd_val;
        if (wr_en_i) begin
            case (cls)
                CL_SWRST:    st_d.swrst = wdata_i & M_SWRST;
                CL_BANK:     st_d.bank = wdata_i[0];
                CL_ALIAS:    st_d.alias_addr = wdata_i[7:1];
                CL_ALIAS_EN: st_d.alias_en = wdata_i[0];
                CL_GP:       gp_we = 1'b1;
                CL_PKT:      st_d.pkt[pkt_bit +: 8] = wdata_i;
                CL_PKT_CTL:  st_d.pkt_ctl = wdata_i[1:0];
                default:     st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o      = st_q.rdata;
    assign err_o        = st_q.err;
    assign rst_ref_o    = st_q.swrst[5];
    assign rst_apath_o  = st_q.swrst[4];
    assign rst_vid_o    = st_q.swrst[3];
    assign rst_aud_o    = st_q.swrst[2];
    assign rst_prot_o   = st_q.swrst[0];
    assign alias_addr_o = st_q.alias_addr;
    assign alias_en_o   = st_q.alias_en;
    assign pkt_en_o     = st_q.pkt_ctl[0];
    assign pkt_rpt_o    = st_q.pkt_ctl[1];
    assign pkt_csum_o   = st_q.pkt[PKT_CSUM_IX*8 +: 8];

    for (genvar k = 0; k < PKT_BYTES - 1; k++) begin : g_payload
        localparam int SRC = (k < PKT_CSUM_IX) ? k : k + 1;
        assign pkt_data_o[k*8 +: 8] = st_q.pkt[SRC*8 +: 8];
    end

    // R9: an error pulse is always caused by a write in the cycle before
    p_err_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en_i));

    // R3: a write to the status offset is flagged
    p_status_write_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_STATUS) |=> err_o);

    // R2: the bank bit moves only on a write
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.bank));

    // R11: read data holds when no read is strobed
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    // R8: unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && cls == CL_NONE) |=> (rdata_o == 8'h00));

    // R7: packet controls change only on a write to their register
    p_pkt_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && cls == CL_PKT_CTL) |=> $stable({pkt_en_o, pkt_rpt_o}));

    // R5: secondary address outputs change only on a write
    p_alias_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable({alias_addr_o, alias_en_o}));

    // R4: reset outputs change only on a write
    p_swrst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable({rst_ref_o, rst_apath_o, rst_vid_o, rst_aud_o, rst_prot_o}));
endmodule

// File: tb/bwin_regwin_tb_top.sv
`timescale 1ns/1ps
module bwin_regwin_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   rdata;
    logic         err;
    logic         hpd = 1'b0;
    logic         vid = 1'b0;
    logic         r_ref, r_apath, r_vid, r_aud, r_prot;
    logic [6:0]   alias_addr;
    logic         alias_en, pkt_en, pkt_rpt;
    logic [103:0] pkt_data;
    logic [7:0]   pkt_csum;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int m_swrst, m_bank, m_alias, m_alias_en, m_pktctl;
    int m_gp [256];
    int m_pkt [14];

    always #2.5 clk = ~clk;

    bwin_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .err_o(err),
        .hpd_i(hpd), .vid_stable_i(vid),
        .rst_ref_o(r_ref), .rst_apath_o(r_apath), .rst_vid_o(r_vid),
        .rst_aud_o(r_aud), .rst_prot_o(r_prot),
        .alias_addr_o(alias_addr), .alias_en_o(alias_en),
        .pkt_en_o(pkt_en), .pkt_rpt_o(pkt_rpt),
        .pkt_data_o(pkt_data), .pkt_csum_o(pkt_csum)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // class codes: 0 none, 1 reset bits, 2 status, 3 bank, 4 alias, 5 alias enable, 6 general, 7 packet, 8 packet control
    function automatic int cls_of(input int a);
        if (a <= 8'h2F) begin
            if (a == 8'h04) return 1;
            if (a == 8'h0E) return 2;
            if (a == 8'h0F) return 3;
            if (a == 8'h1D) return 4;
            if (a == 8'h1E) return 5;
            return 0;
        end
        if (m_bank == 0) return 6;
        if (a >= 8'h58 && a <= 8'h65) return 7;
        if (a == 8'hCD) return 8;
        return 0;
    endfunction

    function automatic int exp_read(input int a);
        case (cls_of(a))
            1: return m_swrst;
            2: return (int'(hpd) << 6) | (int'(vid) << 4);
            3: return m_bank;
            4: return m_alias;
            5: return m_alias_en;
            6: return m_gp[a];
            7: return m_pkt[a - 8'h58];
            8: return m_pktctl;
            default: return 0;
        endcase
    endfunction

    task automatic model_write(input int a, input int d);
        case (cls_of(a))
            1: m_swrst = d & 8'h3D;
            3: m_bank = d & 1;
            4: m_alias = d & 8'hFE;
            5: m_alias_en = d & 1;
            6: m_gp[a] = d;
            7: m_pkt[a - 8'h58] = d;
            8: m_pktctl = d & 3;
            default: ;
        endcase
    endtask

    task automatic chk_outs(input string req);
        chk({r_ref, r_apath, r_vid, r_aud, r_prot},
            {m_swrst[5], m_swrst[4], m_swrst[3], m_swrst[2], m_swrst[0]}, {req, " R4 outputs"});
        chk(alias_addr, m_alias >> 1, {req, " R5 address"});
        chk(alias_en, m_alias_en, {req, " R5 enable"});
        chk({pkt_rpt, pkt_en}, m_pktctl, {req, " R7 controls"});
        chk(pkt_csum, m_pkt[5], {req, " R6 checksum"});
        for (int k = 0; k < 13; k++)
            chk(pkt_data[k*8 +: 8], m_pkt[(k < 5) ? k : k + 1], {req, " R6 payload"});
    endtask

    task automatic wr(input int a, input int d, input string req);
        int exp_err;
        @(negedge clk);
        addr = 8'(a); wdata = 8'(d); wr_en = 1'b1;
        exp_err = (cls_of(a) == 0 || cls_of(a) == 2) ? 1 : 0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(err, exp_err, {req, " R9 error pulse"});
        model_write(a, d);
    endtask

    task automatic rd(input int a, input string req);
        int e;
        @(negedge clk);
        addr = 8'(a); rd_en = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rdata, e, req);
    endtask

    task automatic rdwr(input int a, input int d, input string req);
        int e;
        @(negedge clk);
        addr = 8'(a); wdata = 8'(d); rd_en = 1'b1; wr_en = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk(rdata, e, {req, " R11 read before write"});
        model_write(a, d);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int a, d, op;
        int picks [10] = '{8'h04, 8'h0E, 8'h0F, 8'h1D, 8'h1E, 8'h58, 8'h5D, 8'h65, 8'hCD, 8'h30};
        void'($urandom(32'h5EED_1234));
        m_swrst = 0; m_bank = 0; m_alias = 0; m_alias_en = 0; m_pktctl = 0;
        for (int i = 0; i < 256; i++) m_gp[i] = 0;
        for (int i = 0; i < 14; i++) m_pkt[i] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(rdata, 0, "R10 read data");
        chk(err, 0, "R10 error output");
        chk_outs("R10");
        rd(8'h0F, "R10 bank bit");
        rd(8'h80, "R10 general storage");

        // R1: common region is shared by both banks
        wr(8'h1D, 8'h67, "R1");
        wr(8'h0F, 8'hFF, "R2");
        rd(8'h0F, "R2 only bit 0 kept");
        rd(8'h1D, "R1 alias seen from bank 1");
        wr(8'h04, 8'hFF, "R1");
        chk_outs("R4 all set");
        wr(8'h0F, 8'h00, "R2");
        rd(8'h04, "R1 reset bits seen from bank 0");
        rd(8'h1D, "R5 address bit 0 reads 0");
        chk_outs("R5");

        // R2: bank steering of the upper window
        wr(8'h30, 8'hA5, "R2");
        wr(8'h58, 8'h11, "R2");
        wr(8'h0F, 8'h01, "R2");
        rd(8'h30, "R2 bank 1 offset 0x30 unmapped");
        wr(8'h30, 8'h77, "R9 unmapped write");
        rd(8'h58, "R2 bank 1 packet byte untouched");
        wr(8'h0F, 8'h00, "R2");
        rd(8'h30, "R2 bank 0 storage");
        rd(8'h58, "R2 bank 0 storage separate");

        // R3: status pins and read-only behaviour
        @(negedge clk); hpd = 1'b1; vid = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h0E, "R3 hot-plug bit");
        @(negedge clk); hpd = 1'b0; vid = 1'b1;
        repeat (4) @(negedge clk);
        rd(8'h0E, "R3 video-stable bit");
        wr(8'h0E, 8'hFF, "R3 write to status");
        wr(8'h0E, 8'h00, "R3 back-to-back write to status");
        rd(8'h0E, "R3 status unchanged");

        // R4: reset bit pattern
        wr(8'h04, 8'h08, "R4");
        chk_outs("R4 video only");
        rd(8'h04, "R4 readback");

        // R6, R7: packet registers in bank 1
        wr(8'h0F, 8'h01, "R6");
        for (int i = 0; i < 14; i++) wr(8'h58 + i, 8'h20 + 3 * i, "R6");
        chk_outs("R6 layout");
        rd(8'h5D, "R6 checksum readback");
        wr(8'hCD, 8'hFF, "R7");
        rd(8'hCD, "R7 only two bits kept");
        chk_outs("R7");
        wr(8'hCD, 8'h02, "R7");
        chk_outs("R7 repeat only");

        // R8: unmapped reads
        rd(8'h00, "R8 common gap");
        rd(8'h2F, "R8 common top");
        rd(8'hCE, "R8 bank 1 gap");
        rd(8'h57, "R8 below packet");
        wr(8'h10, 8'h5A, "R9 common gap write");
        rd(8'h10, "R9 gap still reads 0");

        // R11: hold and same-cycle read/write
        rdwr(8'h1E, 8'h01, "R11");
        rd(8'h1E, "R11 write landed");
        repeat (3) @(negedge clk);
        chk(rdata, 1, "R11 read data held");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            a = ($urandom % 2) ? picks[$urandom % 10] : int'($urandom % 256);
            d = int'($urandom % 256);
            op = int'($urandom % 8);
            if (op < 3) wr(a, d, "R9 random write");
            else if (op < 7) rd(a, "R2 random read");
            else rdwr(a, d, "R11 random");
            if (n % 500 == 0) chk_outs("R6 random");
        end
        chk_outs("R4 final");
        finish_run();
    end
endmodule